// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block sits beside the command path of a DDR SDRAM controller. Every cycle it sees one command and a bank number. From these it keeps track of which banks hold an open row. It counts how long each open bank has stayed open and asks for a forced precharge when a bank reaches its maximum open time. It also follows the one data burst that can be in flight on the shared data bus.

A read or write burst can end early in three ways: a precharge to its bank, a precharge to all banks, or a burst-stop command. When a read burst is cut, the block keeps the expected read-data window open for the CAS latency and then closes it. When a write burst is cut, write input stops at once and the data mask is held high for the write-recovery window. Two command errors are reported as one-cycle pulses: an activate sent to a bank that is already open, and a burst-stop sent while a write burst is running.

The controller uses the idle flags and the forced-precharge requests to plan its next commands. It drives the data path with the burst, valid and mask outputs. The maximum open time, the burst length and the write-recovery time are parameters. The CAS latency is an input, given in half-cycles.

Top module: `ddr_bank_tracker`

## Requirements
- R1: Command codes on `cmd`: 0 no-op, 1 activate, 2 read, 3 write, 4 single-bank precharge (bank from `cmd_bank`), 5 all-bank precharge, 6 burst stop. A single-bank precharge makes only the addressed bank idle (`bank_idle` bit = 1 after the edge). Every other open bank stays open.
- R2: An activate to an idle bank clears that bank's `bank_idle` bit after the sampling edge and restarts its open-time count at zero.
- R3: An all-bank precharge is legal whatever the bank states are. Open banks become idle, idle banks stay idle, and no error output pulses.
- R4: `force_pre_req[i]` rises exactly TRAS_MAX clock edges after the edge that opened bank i. It stays high until the bank is precharged, and it clears on the edge that closes the bank.
- R5: A read to an open bank holds `rd_burst` high for BURST_CYC cycles. `rd_valid` follows `rd_burst` delayed by CL cycles, where CL = 2 for `cas_lat_hc` ≤ 4 and CL = 3 for 5 or 6 half-cycles.
- R6: A precharge (single to the burst bank, or all-bank) during a read burst drops `rd_burst` at the next edge. `rd_valid` stays high for exactly CL more cycles and then goes low.
- R7: A precharge that hits the bank of a running write burst drops `wr_en` at the next edge. `wr_mask` is then high for exactly T_WR_CYC cycles.
- R8: A burst stop during a read burst drops `rd_burst` at the next edge. `rd_valid` ends CL cycles later.
- R9: A burst stop during a write burst pulses `err_bst_wr` for one cycle and does not shorten the write burst.
- R10: An activate to a bank that is already open pulses `err_act_open` for one cycle. It does not restart that bank's open-time count.
- R11: While `rst_n` is low at a clock edge, all banks become idle, all counters clear, and every burst, mask and error output is low.
- R12: A read or write addressed to an idle bank is ignored: no burst starts and a running burst is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command code for this cycle (see R1) |
| cmd_bank | input | 2 | Bank the command is addressed to |
| cas_lat_hc | input | 3 | CAS latency in half-cycles (4, 5 or 6) |
| bank_idle | output | 4 | One bit per bank, 1 when the bank is idle |
| force_pre_req | output | 4 | One bit per bank, 1 when the maximum open time is reached |
| rd_burst | output | 1 | A read burst is running on the command side |
| rd_valid | output | 1 | Read data is expected on the data bus |
| wr_en | output | 1 | Write data input is enabled |
| wr_mask | output | 1 | Data mask must be driven high |
| err_act_open | output | 1 | One-cycle pulse: activate sent to an open bank |
| err_bst_wr | output | 1 | One-cycle pulse: burst stop sent during a write |

## Verification
The bench runs directed sequences first. These include a single-bank precharge that must leave a neighbouring bank open, an all-bank precharge issued with a mix of open and idle banks and again with all banks idle, and a bank held open until the open-time limit. Each burst-cut path is also driven on purpose: a precharge or a burst stop part-way through a read, a precharge into a write, and a burst stop into a write. These show whether the read-valid tail, the mask window and the error pulse are timed from the right edge. Random command streams then run under each CAS latency setting, with activates weighted heavily. These streams create back-to-back bursts, bursts that replace one another, reads and writes to idle banks, and long-open banks, and they expose any wrong interaction between bank state and burst state.

// File: rtl/ddr_bank_pkg.sv
// Package: ddr_bank_pkg
// Shared command encoding for the bank state tracker.
// Assumes one command per clock, three bits wide.
package ddr_bank_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_BST  = 3'd6
    } cmd_e;

    // Smallest and largest CAS latency in whole cycles.
    localparam int CL_MIN_CYC = 2;
    localparam int CL_MAX_CYC = 3;

endpackage

// File: rtl/bank_slot.sv
// Module: bank_slot
// State of one bank: open or idle, and a saturating count of the cycles
// the bank has been open. Asks for a forced precharge at TRAS_MAX.
// Assumes act_sel and pre_sel are never high in the same cycle.
module bank_slot #(
    parameter int TRAS_MAX = 40,
    localparam int CNT_W   = $clog2(TRAS_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_sel,
    input  logic pre_sel,
    output logic is_open,
    output logic force_req,
    output logic act_err
);

    logic [CNT_W-1:0] open_cnt;

    // Open/close the bank and count its open cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_cnt <= '0;
        end else if (act_sel && !is_open) begin
            is_open  <= 1'b1;
            open_cnt <= '0;
        end else if (pre_sel) begin
            is_open  <= 1'b0;
            open_cnt <= '0;
        end else if (is_open && open_cnt != CNT_W'(TRAS_MAX)) begin
            open_cnt <= open_cnt + 1'b1;
        end
    end

    // Request a precharge once the open-time limit is reached.
    always_comb force_req = is_open && (open_cnt == CNT_W'(TRAS_MAX));

    // An activate to an open bank is an error.
    always_comb act_err = act_sel && is_open;

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel && !is_open) |=> (is_open && !force_req));

    assert_pre_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel && !act_sel) |=> !is_open);

    assert_req_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !pre_sel) |=> force_req);

    assert_act_open_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel && is_open) |=> is_open);

endmodule

// File: rtl/lat_pipe.sv
// Module: lat_pipe
// Delay line with a tap chosen at run time: dout is din delayed by sel cycles.
// Assumes 1 <= sel <= DEPTH. Any other sel gives 0.
module lat_pipe #(
    parameter int DEPTH  = 3,
    localparam int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);

    logic [DEPTH-1:0] stage;

    // First stage takes the input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= 1'b0;
        else        stage[0] <= din;
    end

    // Later stages shift the bit along.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[g] <= 1'b0;
            else        stage[g] <= stage[g-1];
        end
    end

    // Pick the stage that matches the requested latency.
    always_comb begin
        dout = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i + 1)) dout = stage[i];
        end
    end

endmodule

// File: rtl/burst_ctl.sv
// Module: burst_ctl
// Tracks the one data burst in flight, ends it early on precharge or burst
// stop, times the read-valid tail and the write mask window, and flags a
// burst stop during a write. Assumes a start is only given for an open bank
// and that at most one of start_rd / start_wr / bst is high per cycle.
module burst_ctl #(
    parameter int NUM_BANKS = 4,
    parameter int BURST_CYC = 4,
    parameter int T_WR_CYC  = 3,
    parameter int MAX_CL    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int BC_W     = $clog2(BURST_CYC + 1),
    localparam int WR_W     = $clog2(T_WR_CYC + 1),
    localparam int SEL_W    = $clog2(MAX_CL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_rd,
    input  logic                 start_wr,
    input  logic [BANK_W-1:0]    start_bank,
    input  logic [NUM_BANKS-1:0] pre_sel,
    input  logic                 bst,
    input  logic [SEL_W-1:0]     cl_cyc,
    output logic                 rd_burst,
    output logic                 wr_en,
    output logic                 wr_mask,
    output logic                 rd_valid,
    output logic                 bst_wr_err
);

    logic [BANK_W-1:0] cur_bank;
    logic [BC_W-1:0]   beat_left;
    logic [WR_W-1:0]   mask_left;
    logic              cut_hit;
    logic              start_any;

    // A precharge that hits the bank of the running burst.
    always_comb cut_hit   = (rd_burst || wr_en) && pre_sel[cur_bank];
    always_comb start_any = start_rd || start_wr;

    // Start, run out, or cut the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_burst  <= 1'b0;
            wr_en     <= 1'b0;
            cur_bank  <= '0;
            beat_left <= '0;
        end else if (start_any) begin
            rd_burst  <= start_rd;
            wr_en     <= start_wr;
            cur_bank  <= start_bank;
            beat_left <= BC_W'(BURST_CYC - 1);
        end else if (cut_hit || (bst && rd_burst)) begin
            rd_burst  <= 1'b0;
            wr_en     <= 1'b0;
        end else if (rd_burst || wr_en) begin
            if (beat_left == '0) begin
                rd_burst <= 1'b0;
                wr_en    <= 1'b0;
            end else begin
                beat_left <= beat_left - 1'b1;
            end
        end
    end

    // Hold the data mask for the write-recovery window after a write is cut.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_left <= '0;
        else if (wr_en && cut_hit && !start_any) mask_left <= WR_W'(T_WR_CYC);
        else if (mask_left != '0)                mask_left <= mask_left - 1'b1;
    end

    always_comb wr_mask = (mask_left != '0);

    // Flag a burst stop that arrives during a write.
    always_ff @(posedge clk) begin
        if (!rst_n) bst_wr_err <= 1'b0;
        else        bst_wr_err <= bst && wr_en;
    end

    // Read data is on the bus CL cycles after the command side.
    lat_pipe #(.DEPTH(MAX_CL)) u_rd_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_burst),
        .sel   (cl_cyc),
        .dout  (rd_valid)
    );

    assert_wr_cut_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pre_sel[cur_bank] && !start_any) |=> (!wr_en && wr_mask));

    assert_rd_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_burst && pre_sel[cur_bank] && !start_any) |=> !rd_burst);

    assert_bst_rd_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst && rd_burst && !start_any) |=> !rd_burst);

    assert_bst_wr_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst && wr_en) |=> bst_wr_err);

    assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_burst && wr_en));

endmodule

// File: rtl/ddr_bank_tracker.sv
// Module: ddr_bank_tracker
// Top of the bank state tracker. Decodes the command, feeds one bank_slot
// per bank and the shared burst controller, and registers the activate error.
// Assumes one command per cycle and cas_lat_hc held steady while a read runs.
module ddr_bank_tracker
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRAS_MAX  = 40,
    parameter int BURST_CYC = 4,
    parameter int T_WR_CYC  = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SEL_W    = $clog2(CL_MAX_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [2:0]           cas_lat_hc,
    output logic [NUM_BANKS-1:0] bank_idle,
    output logic [NUM_BANKS-1:0] force_pre_req,
    output logic                 rd_burst,
    output logic                 rd_valid,
    output logic                 wr_en,
    output logic                 wr_mask,
    output logic                 err_act_open,
    output logic                 err_bst_wr
);

    logic [NUM_BANKS-1:0] act_sel;
    logic [NUM_BANKS-1:0] pre_sel;
    logic [NUM_BANKS-1:0] is_open;
    logic [NUM_BANKS-1:0] act_err;
    logic [SEL_W-1:0]     cl_cyc;
    logic                 start_rd;
    logic                 start_wr;
    logic                 is_bst;

    // Decode the command into per-bank selects.
    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            act_sel[i] = (cmd == CMD_ACT) && (cmd_bank == BANK_W'(i));
            pre_sel[i] = (cmd == CMD_PREA) ||
                         ((cmd == CMD_PRE) && (cmd_bank == BANK_W'(i)));
        end
    end

    // A read or write starts a burst only if its bank is open.
    always_comb begin
        start_rd = (cmd == CMD_RD) && is_open[cmd_bank];
        start_wr = (cmd == CMD_WR) && is_open[cmd_bank];
        is_bst   = (cmd == CMD_BST);
    end

    // Round the half-cycle CAS latency up to whole cycles, within limits.
    always_comb begin
        if (cas_lat_hc <= 3'd4) cl_cyc = SEL_W'(CL_MIN_CYC);
        else                    cl_cyc = SEL_W'(CL_MAX_CYC);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_slot #(.TRAS_MAX(TRAS_MAX)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_sel   (act_sel[b]),
            .pre_sel   (pre_sel[b]),
            .is_open   (is_open[b]),
            .force_req (force_pre_req[b]),
            .act_err   (act_err[b])
        );
    end

    always_comb bank_idle = ~is_open;

    // Turn any activate-to-open-bank into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_act_open <= 1'b0;
        else        err_act_open <= |act_err;
    end

    burst_ctl #(
        .NUM_BANKS (NUM_BANKS),
        .BURST_CYC (BURST_CYC),
        .T_WR_CYC  (T_WR_CYC),
        .MAX_CL    (CL_MAX_CYC)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .start_bank (cmd_bank),
        .pre_sel    (pre_sel),
        .bst        (is_bst),
        .cl_cyc     (cl_cyc),
        .rd_burst   (rd_burst),
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .rd_valid   (rd_valid),
        .bst_wr_err (err_bst_wr)
    );

    assert_prea_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PREA) |=> (bank_idle == '1 && !err_act_open));

    assert_idle_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && !is_open[cmd_bank] && !rd_burst && !wr_en)
        |=> (!rd_burst && !wr_en));

endmodule

// File: tb/ddr_bank_tracker_bench.sv
// Bench for ddr_bank_tracker: directed corner cases, then seeded random commands,
// checked each cycle against a reference model kept in bench functions.
module ddr_bank_tracker_bench;

    localparam int NB   = 4;
    localparam int TRAS = 40;
    localparam int BC   = 4;
    localparam int TWR  = 3;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_PRE = 3'd4, C_PREA = 3'd5, C_BST = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = C_NOP;
    logic [1:0] cmd_bank = 2'd0;
    logic [2:0] cas_lat_hc = 3'd4;
    logic [NB-1:0] bank_idle, force_pre_req;
    logic rd_burst, rd_valid, wr_en, wr_mask, err_act_open, err_bst_wr;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ddr_bank_tracker #(.NUM_BANKS(NB), .TRAS_MAX(TRAS), .BURST_CYC(BC), .T_WR_CYC(TWR))
    u_ddr_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
        .cas_lat_hc(cas_lat_hc), .bank_idle(bank_idle), .force_pre_req(force_pre_req),
        .rd_burst(rd_burst), .rd_valid(rd_valid), .wr_en(wr_en), .wr_mask(wr_mask),
        .err_act_open(err_act_open), .err_bst_wr(err_bst_wr)
    );

    // Reference model state.
    bit m_open [NB];
    int m_cnt  [NB];
    bit m_rd, m_wr, m_eact, m_ebst;
    int m_bank, m_left, m_mask;
    bit m_dly [3];

    function automatic int cl_of(input logic [2:0] hc);
        return (hc <= 3'd4) ? 2 : 3;
    endfunction

    function automatic logic [NB-1:0] exp_idle();
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i] = !m_open[i];
        return v;
    endfunction

    function automatic logic [NB-1:0] exp_req();
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i] = m_open[i] && (m_cnt[i] == TRAS);
        return v;
    endfunction

    function automatic bit exp_valid();
        return m_dly[cl_of(cas_lat_hc) - 1];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_cnt[i] = 0; end
        m_rd = 0; m_wr = 0; m_eact = 0; m_ebst = 0; m_bank = 0; m_left = 0; m_mask = 0;
        for (int i = 0; i < 3; i++) m_dly[i] = 0;
    endtask

    // Advance the model by one clock edge from the requirements.
    task automatic model_step(input logic [2:0] c, input int b);
        bit hit, old_open_b;
        old_open_b = m_open[b];
        hit = (m_rd || m_wr) && ((c == C_PRE && b == m_bank) || c == C_PREA);
        m_eact = (c == C_ACT) && m_open[b];
        m_ebst = (c == C_BST) && m_wr;
        m_dly[2] = m_dly[1]; m_dly[1] = m_dly[0]; m_dly[0] = m_rd;
        if (m_wr && hit) m_mask = TWR;
        else if (m_mask > 0) m_mask--;
        if ((c == C_RD || c == C_WR) && old_open_b) begin
            m_rd = (c == C_RD); m_wr = (c == C_WR); m_bank = b; m_left = BC - 1;
        end else if (hit || (c == C_BST && m_rd)) begin
            m_rd = 0; m_wr = 0;
        end else if (m_rd || m_wr) begin
            if (m_left == 0) begin m_rd = 0; m_wr = 0; end
            else m_left--;
        end
        for (int i = 0; i < NB; i++) begin
            if (c == C_ACT && i == b && !m_open[i]) begin m_open[i] = 1; m_cnt[i] = 0; end
            else if ((c == C_PRE && i == b) || c == C_PREA) begin m_open[i] = 0; m_cnt[i] = 0; end
            else if (m_open[i] && m_cnt[i] < TRAS) m_cnt[i]++;
        end
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1", "bank_idle", 32'(bank_idle), 32'(exp_idle()));
        check("R4", "force_pre_req", 32'(force_pre_req), 32'(exp_req()));
        check("R5", "rd_burst", 32'(rd_burst), 32'(m_rd));
        check("R6", "rd_valid", 32'(rd_valid), 32'(exp_valid()));
        check("R7", "wr_en", 32'(wr_en), 32'(m_wr));
        check("R7", "wr_mask", 32'(wr_mask), 32'(m_mask > 0));
        check("R10", "err_act_open", 32'(err_act_open), 32'(m_eact));
        check("R9", "err_bst_wr", 32'(err_bst_wr), 32'(m_ebst));
    endtask

    // Drive one command at the falling edge, take the rising edge, compare at the next falling edge.
    task automatic step(input logic [2:0] c, input int b);
        cmd = c; cmd_bank = 2'(b);
        @(posedge clk);
        model_step(c, b);
        @(negedge clk);
        cmd = C_NOP;
        compare_all();
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) step(C_NOP, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int r;
        int rb;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R11: reset state.
        check("R11", "idle after reset", 32'(bank_idle), 32'hF);
        check("R11", "outputs after reset",
              32'({force_pre_req, rd_burst, rd_valid, wr_en, wr_mask, err_act_open, err_bst_wr}), 32'h0);

        // R2 and R1: open banks 0 and 2, close 0 only.
        step(C_ACT, 0); step(C_ACT, 2);
        check("R2", "two banks open", 32'(bank_idle), 32'b1010);
        step(C_PRE, 0);
        check("R1", "bank 2 stays open", 32'(bank_idle), 32'b1011);

        // R3: all-bank precharge with a mix of states, then with all idle.
        step(C_PREA, 0);
        check("R3", "all idle", 32'(bank_idle), 32'hF);
        step(C_PREA, 3);
        check("R3", "no error on idle PREA", 32'(err_act_open), 32'h0);

        // R10 and R4: reopen an open bank, then hold it to the limit.
        step(C_ACT, 1);
        step(C_ACT, 1);
        check("R10", "double activate flagged", 32'(err_act_open), 32'h1);
        idle_for(TRAS - 2);
        check("R4", "no request one edge early", 32'(force_pre_req), 32'h0);
        step(C_NOP, 0);
        check("R4", "request at limit", 32'(force_pre_req), 32'b0010);

        // R6: cut a read with a precharge, CL = 2 then CL = 3.
        for (int hc = 4; hc <= 5; hc++) begin
            cas_lat_hc = 3'(hc);
            step(C_ACT, 3);
            step(C_RD, 3); step(C_NOP, 0); step(C_NOP, 0);
            step(C_PRE, 3);
            check("R6", "read cut", 32'(rd_burst), 32'h0);
            idle_for(6);
        end

        // R8: burst stop during a read.
        cas_lat_hc = 3'd6;
        step(C_ACT, 3); step(C_RD, 3); step(C_BST, 0);
        check("R8", "read stopped", 32'(rd_burst), 32'h0);
        idle_for(5);

        // R7: precharge into a write.
        step(C_WR, 1); step(C_PREA, 0);
        check("R7", "mask raised", 32'(wr_mask), 32'h1);
        idle_for(5);

        // R9: burst stop into a write.
        step(C_ACT, 2); step(C_WR, 2); step(C_BST, 0);
        check("R9", "stop in write flagged", 32'(err_bst_wr), 32'h1);
        check("R9", "write continues", 32'(wr_en), 32'h1);
        idle_for(5);

        // R12: read and write to an idle bank.
        step(C_RD, 0);
        check("R12", "read to idle ignored", 32'(rd_burst), 32'h0);
        step(C_WR, 0);
        check("R12", "write to idle ignored", 32'(wr_en), 32'h0);

        // Random command streams under each CAS latency.
        for (int phase = 0; phase < 3; phase++) begin
            cas_lat_hc = 3'(4 + phase);
            idle_for(4);
            for (int n = 0; n < 1500; n++) begin
                r  = int'($urandom % 16);
                rb = int'($urandom % NB);
                if (r < 4)       step(C_ACT, rb);
                else if (r < 7)  step(C_RD, rb);
                else if (r < 10) step(C_WR, rb);
                else if (r < 12) step(C_PRE, rb);
                else if (r < 13) step(C_PREA, rb);
                else if (r < 14) step(C_BST, rb);
                else             step(C_NOP, rb);
            end
        end

        // R11: reset in the middle of activity.
        step(C_ACT, 0); step(C_WR, 0);
        do_reset();
        check("R11", "idle after second reset", 32'(bank_idle), 32'hF);
        check("R11", "write cleared by reset", 32'(wr_en), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule